// File: doc/BRIEF.md
# Flash Command Decoder with Status Register

This block sits behind the bus of a byte-wide flash-style memory. The host writes single-byte commands into it and reads a byte back. The meaning of that read byte depends on the current read mode: array contents, identifier codes or the status register. Some commands need a second bus cycle. A byte write takes a command code and then one address/data cycle. A block erase takes a command code and then a confirm code sent to any address inside the target block. A running erase can be suspended, so the host can read the array, and then resumed.

A small busy timer stands in for the internal program/erase engine. Each operation keeps the part busy for a fixed, parameterised number of clock cycles. The timer stops counting while an erase is suspended. The array is a small register-based memory. A byte write stores the data as soon as the operation launches. An erase sets every byte of the block to FFh when its timer expires. The status register holds sticky error flags. Both error flags set together mark a bad command sequence. The supply-level input is sampled only at the moment an operation would start.

Top module: `flashcmd_ctrl`

## Requirements
- R1: After an active-low reset, `rdy` is 1, the status byte is 80h and the read mode is array. No command is needed before array reads.
- R2: Command FFh selects array reads, 90h selects identifier reads and 70h selects status reads. In identifier mode, address bit 0 = 0 returns 89h and bit 0 = 1 returns A0h.
- R3: The status byte is {ready(7), suspended(6), erase error(5), write error(4), supply low(3), 3'b000}. Bit 7 reads 0 while an operation is counting. A suspended erase reads as ready.
- R4: 40h or 10h followed by a cycle (A, D) stores D at A. `rdy` is then low for exactly WR_CYCLES cycles, and the read mode becomes status.
- R5: 20h followed by D0h at address A erases the block A[AW-1:BLK_AW]. `rdy` is low for ER_CYCLES counted cycles. Afterwards every byte of that block reads FFh and other blocks are unchanged. The read mode becomes status.
- R6: If the cycle after 20h carries a byte other than D0h, status bits 5 and 4 are both set. No operation starts and the mode becomes status.
- R7: If `vpp_ok` is low in the launching cycle, bit 3 is set together with bit 4 (write) or bit 5 (erase). No busy time follows and memory is unchanged.
- R8: 50h clears status bits 5, 4 and 3 only. Bits 7 and 6 keep their values and the read mode does not change.
- R9: B0h during a counting erase raises bit 6 and `rdy` on the next cycle and freezes the timer. D0h resumes it. Total busy time across the suspend stays ER_CYCLES.
- R10: While an operation is counting, only 70h and B0h (B0h only for an erase) have an effect. Every other written byte is ignored.
- R11: Reset during an operation aborts it. A block whose erase was aborted keeps its data.
- R12: While suspended, only D0h, FFh, 90h, 70h and 50h act. 40h, 10h and 20h are ignored and start no two-cycle sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, aborts any operation |
| wr_en | input | 1 | Write cycle strobe, one cycle per bus write |
| addr | input | AW | Byte address for writes and reads |
| wdata | input | 8 | Command or data byte |
| vpp_ok | input | 1 | Program/erase supply present, sampled at launch |
| rdata | output | 8 | Read byte for the current read mode (combinational from addr) |
| rdy | output | 1 | High when no operation is counting |

## Verification
The bench builds the block with a 64-byte array split into four 16-byte blocks, a write time of 6 cycles and an erase time of 24 cycles. The short write time still leaves room to issue ignored commands and status reads while the part is busy. The erase time leaves room to suspend partway through, work inside the suspended window and resume. Four blocks let every check that an erase or an ignored command left other blocks untouched look at real neighbours, and a full-array sweep after random writes stays small.

// File: rtl/flc_pkg.sv
package flc_pkg;
   typedef enum logic [1:0] {
      RM_ARRAY  = 2'd0,
      RM_IDENT  = 2'd1,
      RM_STATUS = 2'd2
   } rmode_t;

   typedef enum logic [1:0] {
      SEQ_CMD     = 2'd0,
      SEQ_WDATA   = 2'd1,
      SEQ_CONFIRM = 2'd2
   } seq_t;

   localparam logic [7:0] OP_READ    = 8'hFF;
   localparam logic [7:0] OP_IDENT   = 8'h90;
   localparam logic [7:0] OP_STATUS  = 8'h70;
   localparam logic [7:0] OP_CLEAR   = 8'h50;
   localparam logic [7:0] OP_PROG    = 8'h40;
   localparam logic [7:0] OP_PROG2   = 8'h10;
   localparam logic [7:0] OP_ERASE   = 8'h20;
   localparam logic [7:0] OP_CONFIRM = 8'hD0;
   localparam logic [7:0] OP_SUSPEND = 8'hB0;
endpackage

// File: rtl/flc_timer.sv
module flc_timer #(
   parameter int WR_CYCLES = 16,
   parameter int ER_CYCLES = 200,
   localparam int MAXC = (WR_CYCLES > ER_CYCLES) ? WR_CYCLES : ER_CYCLES,
   localparam int CW = $clog2(MAXC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_wr,
   input  logic          start_er,
   input  logic          freeze,
   output logic          running,
   output logic          is_erase,
   output logic          done,
   output logic [CW-1:0] cnt
);
   assign done = running && !freeze && (cnt == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         running  <= 1'b0;
         is_erase <= 1'b0;
      end else if (start_wr) begin
         cnt      <= CW'(WR_CYCLES);
         running  <= 1'b1;
         is_erase <= 1'b0;
      end else if (start_er) begin
         cnt      <= CW'(ER_CYCLES);
         running  <= 1'b1;
         is_erase <= 1'b1;
      end else if (done) begin
         cnt      <= '0;
         running  <= 1'b0;
         is_erase <= 1'b0;
      end else if (running && !freeze) begin
         cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/flc_array.sv
module flc_array #(
   parameter int AW     = 8,
   parameter int BLK_AW = 5,
   localparam int DEPTH = 1 << AW,
   localparam int BW    = AW - BLK_AW
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic          erase_go,
   input  logic [BW-1:0] erase_blk,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [7:0] cells [DEPTH];

   function automatic logic [BW-1:0] blk_of(input int idx);
      logic [AW-1:0] a;
      a = AW'(idx);
      return a[AW-1:BLK_AW];
   endfunction

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (erase_go && (blk_of(i) == erase_blk))
            cells[i] <= 8'hFF;
         else if (we && (waddr == AW'(i)))
            cells[i] <= wdata;
      end
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/flc_decode.sv
module flc_decode
   import flc_pkg::*;
#(
   parameter int AW     = 8,
   parameter int BLK_AW = 5,
   localparam int BW    = AW - BLK_AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [BW-1:0] blk_in,
   input  logic [7:0]    wdata,
   input  logic          vpp_ok,
   input  logic          op_running,
   input  logic          op_erase,
   input  logic          op_done,
   output logic          start_wr,
   output logic          start_er,
   output logic          susp,
   output logic [BW-1:0] erase_blk,
   output rmode_t        mode,
   output logic [7:0]    status,
   output logic          at_cmd,
   output logic          at_confirm
);
   seq_t seq;
   logic err_er, err_wr, vpp_low;
   logic busy;

   assign busy       = op_running && !susp;
   assign at_cmd     = (seq == SEQ_CMD);
   assign at_confirm = (seq == SEQ_CONFIRM);
   assign start_wr   = wr_en && (seq == SEQ_WDATA) && vpp_ok;
   assign start_er   = wr_en && at_confirm && (wdata == OP_CONFIRM) && vpp_ok;
   assign status     = {!busy, susp, err_er, err_wr, vpp_low, 3'b000};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq       <= SEQ_CMD;
         mode      <= RM_ARRAY;
         err_er    <= 1'b0;
         err_wr    <= 1'b0;
         vpp_low   <= 1'b0;
         susp      <= 1'b0;
         erase_blk <= '0;
      end else if (wr_en) begin
         unique case (seq)
            SEQ_CMD: begin
               if (busy) begin
                  if (wdata == OP_STATUS)
                     mode <= RM_STATUS;
                  else if (wdata == OP_SUSPEND && op_erase && !op_done) begin
                     susp <= 1'b1;
                     mode <= RM_STATUS;
                  end
               end else begin
                  case (wdata)
                     OP_READ:   mode <= RM_ARRAY;
                     OP_IDENT:  mode <= RM_IDENT;
                     OP_STATUS: mode <= RM_STATUS;
                     OP_CLEAR: begin
                        err_er  <= 1'b0;
                        err_wr  <= 1'b0;
                        vpp_low <= 1'b0;
                     end
                     OP_CONFIRM: begin
                        if (susp) begin
                           susp <= 1'b0;
                           mode <= RM_STATUS;
                        end
                     end
                     OP_PROG, OP_PROG2: if (!susp) seq <= SEQ_WDATA;
                     OP_ERASE:          if (!susp) seq <= SEQ_CONFIRM;
                     default: ;
                  endcase
               end
            end
            SEQ_WDATA: begin
               seq  <= SEQ_CMD;
               mode <= RM_STATUS;
               if (!vpp_ok) begin
                  err_wr  <= 1'b1;
                  vpp_low <= 1'b1;
               end
            end
            SEQ_CONFIRM: begin
               seq  <= SEQ_CMD;
               mode <= RM_STATUS;
               if (wdata == OP_CONFIRM) begin
                  if (vpp_ok) begin
                     erase_blk <= blk_in;
                  end else begin
                     err_er  <= 1'b1;
                     vpp_low <= 1'b1;
                  end
               end else begin
                  err_er <= 1'b1;
                  err_wr <= 1'b1;
               end
            end
            default: seq <= SEQ_CMD;
         endcase
      end
   end
endmodule

// File: rtl/flashcmd_ctrl.sv
module flashcmd_ctrl
   import flc_pkg::*;
#(
   parameter int         AW        = 8,
   parameter int         BLK_AW    = 5,
   parameter int         WR_CYCLES = 16,
   parameter int         ER_CYCLES = 200,
   parameter logic [7:0] MFR_CODE  = 8'h89,
   parameter logic [7:0] DEV_CODE  = 8'hA0,
   localparam int        BW        = AW - BLK_AW,
   localparam int        MAXC      = (WR_CYCLES > ER_CYCLES) ? WR_CYCLES : ER_CYCLES,
   localparam int        CW        = $clog2(MAXC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   input  logic          vpp_ok,
   output logic [7:0]    rdata,
   output logic          rdy
);
   generate
      if (AW < 2 || AW > 12) begin : g_bad_aw
         $error("flashcmd_ctrl: AW out of range");
      end
      if (BLK_AW < 1 || BLK_AW >= AW) begin : g_bad_blk
         $error("flashcmd_ctrl: BLK_AW must be below AW");
      end
      if (WR_CYCLES < 1 || ER_CYCLES < 1) begin : g_bad_time
         $error("flashcmd_ctrl: busy times must be at least one cycle");
      end
   endgenerate

   logic          start_wr, start_er, susp, at_cmd, at_confirm;
   logic          running, is_erase, done;
   logic [CW-1:0] tcnt;
   logic [BW-1:0] erase_blk;
   logic [7:0]    status_w, arr_rd;
   rmode_t        mode;

   flc_decode #(.AW(AW), .BLK_AW(BLK_AW)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .blk_in     (addr[AW-1:BLK_AW]),
      .wdata      (wdata),
      .vpp_ok     (vpp_ok),
      .op_running (running),
      .op_erase   (is_erase),
      .op_done    (done),
      .start_wr   (start_wr),
      .start_er   (start_er),
      .susp       (susp),
      .erase_blk  (erase_blk),
      .mode       (mode),
      .status     (status_w),
      .at_cmd     (at_cmd),
      .at_confirm (at_confirm)
   );

   flc_timer #(.WR_CYCLES(WR_CYCLES), .ER_CYCLES(ER_CYCLES)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_wr (start_wr),
      .start_er (start_er),
      .freeze   (susp),
      .running  (running),
      .is_erase (is_erase),
      .done     (done),
      .cnt      (tcnt)
   );

   flc_array #(.AW(AW), .BLK_AW(BLK_AW)) u_arr (
      .clk       (clk),
      .we        (start_wr),
      .waddr     (addr),
      .wdata     (wdata),
      .erase_go  (done && is_erase),
      .erase_blk (erase_blk),
      .raddr     (addr),
      .rdata     (arr_rd)
   );

   assign rdy = !(running && !susp);

   always_comb begin
      unique case (mode)
         RM_IDENT:  rdata = addr[0] ? DEV_CODE : MFR_CODE;
         RM_STATUS: rdata = status_w;
         default:   rdata = arr_rd;
      endcase
   end
endmodule

// File: rtl/flc_chk.sv
module flc_chk
   import flc_pkg::*;
#(
   parameter int CW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [7:0]    wdata,
   input logic          rdy,
   input logic [7:0]    status,
   input logic          susp,
   input rmode_t        mode,
   input logic          at_cmd,
   input logic          at_confirm,
   input logic [CW-1:0] tcnt
);
   // R3
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status[2:0] == 3'b000) && (status[6] -> status[7]));

   // R6
   bad_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (at_confirm && wr_en && wdata != OP_CONFIRM) |=> (status[5:4] == 2'b11) && rdy);

   // R8
   clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (at_cmd && rdy && wr_en && wdata == OP_CLEAR) |=> (status[5:3] == 3'b000));

   // R9
   suspend_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      susp |-> rdy);

   // R9
   suspend_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      susp |=> $stable(tcnt));

   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy && wr_en && wdata == OP_READ) |=> (mode == $past(mode)));
endmodule

bind flashcmd_ctrl flc_chk #(.CW(CW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wdata      (wdata),
   .rdy        (rdy),
   .status     (status_w),
   .susp       (susp),
   .mode       (mode),
   .at_cmd     (at_cmd),
   .at_confirm (at_confirm),
   .tcnt       (tcnt)
);

// File: tb/flashcmd_ctrl_tb.sv
`timescale 1ns/1ps
module flashcmd_ctrl_tb_top;
   localparam int AW = 6;
   localparam int BLK_AW = 4;
   localparam int WR = 6;
   localparam int ER = 24;
   localparam int DEPTH = 1 << AW;
   localparam int NBLK = 1 << (AW - BLK_AW);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic          vpp_ok = 1'b1;
   logic [7:0]    rdata;
   logic          rdy;

   int checks = 0;
   int errors = 0;
   int busy_cnt = 0;
   logic [7:0] model [DEPTH];

   flashcmd_ctrl #(.AW(AW), .BLK_AW(BLK_AW), .WR_CYCLES(WR), .ER_CYCLES(ER)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .vpp_ok(vpp_ok), .rdata(rdata), .rdy(rdy)
   );

   always #2.5 clk = ~clk;

   always @(negedge clk) if (rst_n && !rdy) busy_cnt++;

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   function automatic logic [7:0] stat(input logic r, s, ee, we, vl);
      return {r, s, ee, we, vl, 3'b000};
   endfunction

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
      @(negedge clk);
      addr = a;
      #1 v = rdata;
   endtask

   task automatic wait_rdy();
      int n = 0;
      while (!rdy && n < 5000) begin
         @(negedge clk);
         n++;
      end
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      logic [7:0] v;
      int seed;
      seed = $urandom(32'd4711);
      do_reset();
      // R1 reset state
      chk("R1 rdy", {7'd0, rdy}, 8'd1);
      wr('0, 8'h70);
      rd('0, v); chk("R1 status", v, 8'h80);

      // R5 erase every block, time the first
      for (int b = 0; b < NBLK; b++) begin
         busy_cnt = 0;
         wr('0, 8'h20);
         wr(AW'(b << BLK_AW), 8'hD0);
         wait_rdy();
         if (b == 0) chk("R5 erase busy cycles", 8'(busy_cnt), 8'(ER));
      end
      for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
      rd('0, v); chk("R5 status after erase", v, 8'h80);
      wr('0, 8'hFF);
      rd(6'd0, v); chk("R5 erased", v, 8'hFF);
      rd(6'd63, v); chk("R5 erased", v, 8'hFF);

      // R2 identifier codes
      wr('0, 8'h90);
      rd(6'd0, v); chk("R2 mfr", v, 8'h89);
      rd(6'd1, v); chk("R2 dev", v, 8'hA0);
      rd(6'd2, v); chk("R2 mfr even", v, 8'h89);

      // R4 byte write with 40h; R3 busy status; R10 ignored command
      busy_cnt = 0;
      wr('0, 8'h40);
      wr(6'd5, 8'h3C); model[5] = 8'h3C;
      rd('0, v); chk("R3 busy status", v, stat(0, 0, 0, 0, 0));
      wr('0, 8'hFF);
      wait_rdy();
      chk("R4 write busy cycles", 8'(busy_cnt), 8'(WR));
      rd('0, v); chk("R10 mode kept status", v, 8'h80);
      wr('0, 8'hFF);
      rd(6'd5, v); chk("R4 data", v, 8'h3C);

      // R4 alternate code 10h
      busy_cnt = 0;
      wr('0, 8'h10);
      wr(6'd21, 8'h5A); model[21] = 8'h5A;
      wait_rdy();
      chk("R4 alt busy", 8'(busy_cnt), 8'(WR));
      wr('0, 8'hFF);
      rd(6'd21, v); chk("R4 alt data", v, 8'h5A);

      // R5 erase block 0 only
      wr('0, 8'h20);
      wr(6'd9, 8'hD0);
      wait_rdy();
      model[5] = 8'hFF;
      wr('0, 8'hFF);
      rd(6'd5, v); chk("R5 block0 erased", v, 8'hFF);
      rd(6'd21, v); chk("R5 block1 kept", v, 8'h5A);

      // R6 improper confirm
      busy_cnt = 0;
      wr('0, 8'h20);
      wr(6'd16, 8'h55);
      rd('0, v); chk("R6 status", v, stat(1, 0, 1, 1, 0));
      chk("R6 no busy", 8'(busy_cnt), 8'd0);
      wr('0, 8'hFF);
      rd(6'd21, v); chk("R6 memory kept", v, 8'h5A);
      // R8 clear, mode unchanged
      wr('0, 8'h50);
      rd(6'd21, v); chk("R8 mode kept array", v, 8'h5A);
      wr('0, 8'h70);
      rd('0, v); chk("R8 cleared", v, 8'h80);

      // R7 supply low
      vpp_ok = 1'b0;
      busy_cnt = 0;
      wr('0, 8'h40);
      wr(6'd21, 8'h00);
      rd('0, v); chk("R7 write status", v, stat(1, 0, 0, 1, 1));
      wr('0, 8'h50);
      wr('0, 8'h20);
      wr(6'd16, 8'hD0);
      rd('0, v); chk("R7 erase status", v, stat(1, 0, 1, 0, 1));
      chk("R7 no busy", 8'(busy_cnt), 8'd0);
      vpp_ok = 1'b1;
      wr('0, 8'h50);
      wr('0, 8'hFF);
      rd(6'd21, v); chk("R7 memory kept", v, 8'h5A);

      // R9 suspend/resume of block 2 erase
      wr('0, 8'h40); wr(6'd40, 8'h11); wait_rdy();
      busy_cnt = 0;
      wr('0, 8'h20);
      wr(6'd40, 8'hD0);
      repeat (5) @(negedge clk);
      wr('0, 8'hB0);
      chk("R9 rdy in suspend", {7'd0, rdy}, 8'd1);
      rd('0, v); chk("R9 suspend status", v, stat(1, 1, 0, 0, 0));
      wr('0, 8'h50);
      rd('0, v); chk("R8 keeps bit6", v, stat(1, 1, 0, 0, 0));
      // R12 write command ignored while suspended
      wr('0, 8'h40);
      wr(6'd22, 8'h77);
      wr('0, 8'hFF);
      rd(6'd22, v); chk("R12 ignored write", v, 8'hFF);
      rd(6'd40, v); chk("R9 block readable", v, 8'h11);
      wr('0, 8'hD0);
      wait_rdy();
      chk("R9 total busy", 8'(busy_cnt), 8'(ER));
      rd('0, v); chk("R9 done status", v, 8'h80);
      wr('0, 8'hFF);
      rd(6'd40, v); chk("R9 erased", v, 8'hFF);

      // R11 reset aborts erase of block 3
      wr('0, 8'h40); wr(6'd50, 8'h66); wait_rdy();
      model[50] = 8'h66;
      wr('0, 8'h20);
      wr(6'd50, 8'hD0);
      repeat (3) @(negedge clk);
      do_reset();
      chk("R11 rdy", {7'd0, rdy}, 8'd1);
      rd(6'd50, v); chk("R11 R1 array kept", v, 8'h66);
      wr('0, 8'h70);
      rd('0, v); chk("R11 status", v, 8'h80);

      // R4 R7 random writes
      for (int k = 0; k < 30; k++) begin
         logic [AW-1:0] a;
         logic [7:0]    d;
         logic          good;
         a = AW'($urandom % DEPTH);
         d = 8'($urandom);
         good = ($urandom % 6) != 0;
         vpp_ok = good;
         busy_cnt = 0;
         wr('0, (k % 2) ? 8'h40 : 8'h10);
         wr(a, d);
         vpp_ok = 1'b1;
         wait_rdy();
         if (good) begin
            model[a] = d;
            chk("R4 random busy", 8'(busy_cnt), 8'(WR));
            rd('0, v); chk("R4 random status", v, 8'h80);
         end else begin
            rd('0, v); chk("R7 random status", v, stat(1, 0, 0, 1, 1));
            wr('0, 8'h50);
         end
      end
      wr('0, 8'hFF);
      for (int i = 0; i < DEPTH; i++) begin
         rd(AW'(i), v); chk("R4 sweep", v, model[i]);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule